// File: doc/BRIEF.md
# Horizontal Drive Soft Start/Stop Sequencer

This block produces the horizontal drive pulse for a deflection output stage and controls how it starts and stops. The pulse is built from a reference tick that arrives at twice the line rate. During the soft phases the block drives one pulse per tick with a 75% duty. In normal operation it drives one pulse per two ticks, high for the whole first tick interval. Start-up and shut-down each pass through fixed dwell periods counted in ticks. During shut-down the block also drives a control code that first pushes the RGB drive to maximum, to discharge the tube, and then to minimum.

The drive is held off until the configuration registers have been written and the oscillator calibration has finished, with no power-on reset pending. Both conditions are armed by rising edges of their flags. A power-on reset or a flash-protection event removes the drive in the same clock cycle. A loss of line lock during normal running stops the drive and requests a new calibration. The overvoltage input either forces a soft stop or, when the mode bit is set, leaves the drive running and sets a sticky status bit. The pulse is also blanked whenever the flyback input is high.

Top module: `hdrive_softctl`

## Requirements
- R1: After reset, hdrive, recal_req and ovp_flag are 0 and rgb_mode is 0 (normal). The drive stays off until a rising edge of regs_loaded and a rising edge of cal_done have both been seen since the last reset or power-on reset. Once both are seen, with por, flash_prot, off_req and a stopping overvoltage all low, the soft start begins on the next tick.
- R2: Soft start lasts UP_TICKS tick intervals. In each interval, hdrive is high for the first floor(3*TICK_CLKS/4) clock cycles after the tick edge.
- R3: After the soft start, hdrive runs at normal frequency. The first tick interval is fully high, the next fully low, and the pattern alternates from there.
- R4: off_req high during soft start or normal running starts the soft stop at the next tick. The soft stop has DRAIN_TICKS double-rate intervals with rgb_mode=1 (maximum), then BLANK_TICKS double-rate intervals with rgb_mode=2 (minimum). After that hdrive stays low with rgb_mode=0 until off_req falls, and then the soft start runs again.
- R5: por high forces hdrive low in the same cycle and returns the sequencer to off. Restarting then needs new rising edges of both regs_loaded and cal_done.
- R6: locked low during normal running gives a one-cycle recal_req pulse in the next cycle, and hdrive is low from that cycle on. Restarting needs a new rising edge of cal_done; an unchanged high cal_done is not enough.
- R7: flash_prot high forces hdrive low in the same cycle. Once it falls, the drive restarts through the full soft start without any new configuration or calibration.
- R8: ovp_prot high with ovp_cont=0 during running starts the same soft stop as R4 and leaves ovp_flag at 0. No restart happens while ovp_prot stays high.
- R9: ovp_prot high with ovp_cont=1 leaves the drive pattern unchanged and sets ovp_flag from the next cycle. The flag stays set until a stat_clr cycle in which no new set occurs; a set in the same cycle as stat_clr wins.
- R10: hdrive is low in every cycle in which flyback is high, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe at twice the line rate |
| por | input | 1 | Power-on reset detected |
| regs_loaded | input | 1 | All configuration registers written |
| cal_done | input | 1 | Oscillator calibration finished |
| locked | input | 1 | Coincidence detector reports line lock |
| flash_prot | input | 1 | Flash protection active |
| ovp_prot | input | 1 | Overvoltage protection active |
| ovp_cont | input | 1 | Overvoltage mode: 1 keeps driving and flags, 0 stops softly |
| off_req | input | 1 | Switch-off request |
| stat_clr | input | 1 | Read-clear strobe for ovp_flag |
| flyback | input | 1 | Flyback pulse present |
| hdrive | output | 1 | Horizontal drive pulse |
| rgb_mode | output | 2 | RGB drive control: 0 normal, 1 maximum, 2 minimum |
| ovp_flag | output | 1 | Sticky overvoltage status |
| recal_req | output | 1 | One-cycle request to repeat calibration |

## Verification
Drive-pattern results are due in the tick interval that starts at the clock edge registering the tick. The bench therefore drives each tick and then counts hdrive over exactly TICK_CLKS samples taken one nanosecond after each following falling edge, and compares that count and the rgb_mode value at the end of the interval with the expected value. The kill paths (por, flash_prot, flyback) act in the same cycle, so the bench checks hdrive one nanosecond after changing those inputs. recal_req and ovp_flag lag their cause by one register, so the bench checks them at the next falling edge, and checks again one edge later to confirm recal_req lasts one cycle and ovp_flag stays set.

// File: rtl/hd_pkg.sv
package hd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SOFTUP = 3'd1,
    ST_RUN    = 3'd2,
    ST_DRAIN  = 3'd3,
    ST_BLANK  = 3'd4
  } hd_state_t;

  typedef enum logic [1:0] {
    RGB_NORM = 2'd0,
    RGB_MAX  = 2'd1,
    RGB_MIN  = 2'd2
  } rgb_ctl_t;

  // high time of a double-rate pulse: three quarters of one tick interval
  function automatic int unsigned dbl_high_len(int unsigned tclks);
    return (3 * tclks) / 4;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic is_driving(hd_state_t s);
    return s != ST_IDLE;
  endfunction

  function automatic logic is_double(hd_state_t s);
    return (s == ST_SOFTUP) || (s == ST_DRAIN) || (s == ST_BLANK);
  endfunction

  function automatic rgb_ctl_t rgb_for(hd_state_t s);
    case (s)
      ST_DRAIN: return RGB_MAX;
      ST_BLANK: return RGB_MIN;
      default:  return RGB_NORM;
    endcase
  endfunction

endpackage

// File: rtl/hd_phase.sv
module hd_phase
  import hd_pkg::*;
#(
  parameter int unsigned TICK_CLKS = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic lp_load,
  output logic dbl_pulse,
  output logic norm_pulse
);
  localparam int unsigned PW   = $clog2(TICK_CLKS) + 1;
  localparam int unsigned HI   = dbl_high_len(TICK_CLKS);
  localparam logic [PW-1:0] HI_V   = PW'(HI);
  localparam logic [PW-1:0] PH_MAX = '1;

  logic [PW-1:0] ph;
  logic          lp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_MAX;
      lp <= 1'b0;
    end else if (tick) begin
      ph <= '0;
      lp <= lp_load ? 1'b1 : ~lp;
    end else if (ph != PH_MAX) begin
      ph <= ph + 1'b1;
    end
  end

  assign dbl_pulse  = (ph < HI_V);
  assign norm_pulse = lp;

  // R2
  tick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (ph == '0));

  // R3
  load_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lp_load) |=> norm_pulse);

endmodule

// File: rtl/hd_dwell.sv
module hd_dwell
  import hd_pkg::*;
#(
  parameter int unsigned UP_TICKS    = 1562,
  parameter int unsigned DRAIN_TICKS = 3125,
  parameter int unsigned BLANK_TICKS = 1562
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      restart,
  input  hd_state_t st,
  output logic      expire
);
  localparam int unsigned LMAX = max3(UP_TICKS, DRAIN_TICKS, BLANK_TICKS);
  localparam int unsigned CW   = $clog2(LMAX + 1) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          timed;

  always_comb begin
    timed = 1'b1;
    case (st)
      ST_SOFTUP: lim = CW'(UP_TICKS);
      ST_DRAIN:  lim = CW'(DRAIN_TICKS);
      ST_BLANK:  lim = CW'(BLANK_TICKS);
      default: begin
        lim   = CW'(1);
        timed = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart)                 cnt <= '0;
    else if (tick && (cnt != '1))     cnt <= cnt + 1'b1;
  end

  assign expire = tick && timed && (cnt == (lim - CW'(1)));

  // R4
  dwell_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timed && !$past(restart) && $past(timed)) |-> (cnt < lim));

endmodule

// File: rtl/hd_seq.sv
module hd_seq
  import hd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      por,
  input  logic      regs_loaded,
  input  logic      cal_done,
  input  logic      locked,
  input  logic      flash_prot,
  input  logic      ovp_prot,
  input  logic      ovp_cont,
  input  logic      off_req,
  input  logic      stat_clr,
  input  logic      expire,
  output hd_state_t st,
  output logic      restart,
  output logic      lp_load,
  output logic      recal_req,
  output logic      ovp_flag
);
  hd_state_t st_nx;
  logic cfg_ok, cal_ok, cfg_d, cal_d;
  logic kill, stop_cmd, lock_lost, start_ok, cfg_rise, cal_rise, ovp_set;

  assign kill      = por | flash_prot;
  assign stop_cmd  = off_req | (ovp_prot & ~ovp_cont);
  assign lock_lost = (st == ST_RUN) & ~locked & ~kill;
  assign start_ok  = cfg_ok & cal_ok & ~kill & ~stop_cmd;
  assign cfg_rise  = regs_loaded & ~cfg_d;
  assign cal_rise  = cal_done & ~cal_d;
  assign ovp_set   = ovp_prot & ovp_cont;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:
        if (start_ok && tick) st_nx = ST_SOFTUP;
      ST_SOFTUP:
        if (kill)                    st_nx = ST_IDLE;
        else if (stop_cmd && tick)   st_nx = ST_DRAIN;
        else if (expire)             st_nx = ST_RUN;
      ST_RUN:
        if (kill || lock_lost)       st_nx = ST_IDLE;
        else if (stop_cmd && tick)   st_nx = ST_DRAIN;
      ST_DRAIN:
        if (kill)                    st_nx = ST_IDLE;
        else if (expire)             st_nx = ST_BLANK;
      ST_BLANK:
        if (kill || expire)          st_nx = ST_IDLE;
      default:                       st_nx = ST_IDLE;
    endcase
  end

  assign restart = (st_nx != st);
  assign lp_load = (st == ST_SOFTUP) && (st_nx == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cfg_ok    <= 1'b0;
      cal_ok    <= 1'b0;
      cfg_d     <= 1'b0;
      cal_d     <= 1'b0;
      recal_req <= 1'b0;
      ovp_flag  <= 1'b0;
    end else begin
      st        <= st_nx;
      cfg_d     <= regs_loaded;
      cal_d     <= cal_done;
      cfg_ok    <= ~por & (cfg_ok | cfg_rise);
      cal_ok    <= ~(por | lock_lost) & (cal_ok | cal_rise);
      recal_req <= lock_lost;
      ovp_flag  <= ovp_set | (ovp_flag & ~stat_clr);
    end
  end

  // R1
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SOFTUP && $past(st) != ST_SOFTUP) |-> ($past(st) == ST_IDLE && $past(tick)));

  // R5
  por_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por |=> (st == ST_IDLE && !cfg_ok));

  // R7
  flash_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_prot |=> (st == ST_IDLE));

  // R6
  recal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |-> (st == ST_IDLE && !cal_ok && !$past(locked)));

  // R8
  ovp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_prot && !ovp_cont && st == ST_RUN && tick && !kill) |=> (st == ST_DRAIN));

  // R9
  ovp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovp_flag) |-> $past(ovp_prot && ovp_cont));

endmodule

// File: rtl/hdrive_softctl.sv
module hdrive_softctl
  import hd_pkg::*;
#(
  parameter int unsigned TICK_CLKS   = 1600,
  parameter int unsigned UP_TICKS    = 1562,
  parameter int unsigned DRAIN_TICKS = 3125,
  parameter int unsigned BLANK_TICKS = 1562
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       por,
  input  logic       regs_loaded,
  input  logic       cal_done,
  input  logic       locked,
  input  logic       flash_prot,
  input  logic       ovp_prot,
  input  logic       ovp_cont,
  input  logic       off_req,
  input  logic       stat_clr,
  input  logic       flyback,
  output logic       hdrive,
  output logic [1:0] rgb_mode,
  output logic       ovp_flag,
  output logic       recal_req
);
  hd_state_t st;
  logic restart, lp_load, expire, dbl_pulse, norm_pulse, raw_pulse, gate_ok;

  hd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .por(por),
    .regs_loaded(regs_loaded), .cal_done(cal_done), .locked(locked),
    .flash_prot(flash_prot), .ovp_prot(ovp_prot), .ovp_cont(ovp_cont),
    .off_req(off_req), .stat_clr(stat_clr), .expire(expire),
    .st(st), .restart(restart), .lp_load(lp_load),
    .recal_req(recal_req), .ovp_flag(ovp_flag)
  );

  hd_dwell #(
    .UP_TICKS(UP_TICKS), .DRAIN_TICKS(DRAIN_TICKS), .BLANK_TICKS(BLANK_TICKS)
  ) u_dwell (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
    .st(st), .expire(expire)
  );

  hd_phase #(.TICK_CLKS(TICK_CLKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lp_load(lp_load),
    .dbl_pulse(dbl_pulse), .norm_pulse(norm_pulse)
  );

  assign raw_pulse = is_driving(st) & (is_double(st) ? dbl_pulse : norm_pulse);
  assign gate_ok   = ~flyback & ~flash_prot & ~por;
  assign hdrive    = raw_pulse & gate_ok;
  assign rgb_mode  = rgb_for(st);

  // R4
  rgb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_mode == RGB_MIN && $past(rgb_mode) != RGB_MIN) |-> ($past(rgb_mode) == RGB_MAX));

  // R4
  rgb_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_mode != RGB_NORM) |-> (is_double(st) && !$past(tick && lp_load)));

endmodule

// File: tb/sim_hdrive_softctl.sv
module sim_hdrive_softctl;
  localparam int T  = 8;
  localparam int NU = 3;
  localparam int ND = 4;
  localparam int NB = 2;
  localparam int HI = T - T / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, por = 0, regs_loaded = 0, cal_done = 0, locked = 1;
  logic flash_prot = 0, ovp_prot = 0, ovp_cont = 0, off_req = 0, stat_clr = 0, flyback = 0;
  logic hdrive, ovp_flag, recal_req;
  logic [1:0] rgb_mode;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hdrive_softctl #(.TICK_CLKS(T), .UP_TICKS(NU), .DRAIN_TICKS(ND), .BLANK_TICKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .por(por), .regs_loaded(regs_loaded),
    .cal_done(cal_done), .locked(locked), .flash_prot(flash_prot), .ovp_prot(ovp_prot),
    .ovp_cont(ovp_cont), .off_req(off_req), .stat_clr(stat_clr), .flyback(flyback),
    .hdrive(hdrive), .rgb_mode(rgb_mode), .ovp_flag(ovp_flag), .recal_req(recal_req)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one tick interval: tick edge, then T samples taken 1 ns after each falling edge
  task automatic win(input logic [T-1:0] fb, output int hi, output int rgb);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    hi = 0;
    for (int j = 0; j < T; j++) begin
      flyback = fb[j];
      #1;
      hi += int'(hdrive);
      if (j < T - 1) @(negedge clk);
    end
    flyback = 1'b0;
    rgb = int'(rgb_mode);
  endtask

  task automatic expw(string req, int exp_hi, int exp_rgb, input logic [T-1:0] fb = '0);
    int hi, rgb;
    win(fb, hi, rgb);
    chk(req, hi, exp_hi);
    chk(req, rgb, exp_rgb);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic soft_start(string req);
    for (int i = 0; i < NU; i++) expw(req, HI, 0);
  endtask

  task automatic soft_stop(string req);
    for (int i = 0; i < ND; i++) expw(req, HI, 1);
    for (int i = 0; i < NB; i++) expw(req, HI, 2);
    expw(req, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 hdrive", int'(hdrive), 0);
    chk("R1 rgb", int'(rgb_mode), 0);
    chk("R1 ovp_flag", int'(ovp_flag), 0);
    chk("R1 recal", int'(recal_req), 0);
    expw("R1 nothing armed", 0, 0);
    regs_loaded = 1; idle(2);
    expw("R1 no calibration yet", 0, 0);
    cal_done = 1; idle(2);
    // R2 soft start, R3 normal run
    soft_start("R2 soft start");
    expw("R3 run high", T, 0);
    expw("R3 run low", 0, 0);
    // R10 flyback in a normal high interval, cycles 2..4
    expw("R10 flyback run", T - 3, 0, 8'b0001_1100);
    expw("R3 run low", 0, 0);
    // R9 overvoltage with continue mode
    ovp_prot = 1; ovp_cont = 1; idle(1);
    ovp_prot = 0; idle(1);
    chk("R9 flag set", int'(ovp_flag), 1);
    expw("R9 drive continues", T, 0);
    expw("R9 drive continues", 0, 0);
    chk("R9 flag sticky", int'(ovp_flag), 1);
    stat_clr = 1; ovp_prot = 1; idle(1);
    chk("R9 set beats clear", int'(ovp_flag), 1);
    ovp_prot = 0; idle(1);
    stat_clr = 0; idle(1);
    chk("R9 cleared", int'(ovp_flag), 0);
    ovp_cont = 0;
    // R6 lock loss
    locked = 0; idle(1);
    chk("R6 recal pulse", int'(recal_req), 1);
    chk("R6 drive off", int'(hdrive), 0);
    locked = 1; idle(1);
    chk("R6 recal one cycle", int'(recal_req), 0);
    expw("R6 stale cal_done ignored", 0, 0);
    cal_done = 0; idle(1); cal_done = 1; idle(2);
    expw("R10 flyback double", HI - 2, 0, 8'b0000_0011);
    expw("R6 restart", HI, 0);
    expw("R6 restart", HI, 0);
    expw("R3 run high", T, 0);
    // R7 flash
    idle(2);
    chk("R3 high held", int'(hdrive), 1);
    flash_prot = 1; #1;
    chk("R7 same-cycle cut", int'(hdrive), 0);
    expw("R7 held off", 0, 0);
    flash_prot = 0; idle(1);
    soft_start("R7 soft restart");
    expw("R7 run high", T, 0);
    expw("R7 run low", 0, 0);
    // R4 switch-off
    off_req = 1;
    soft_stop("R4 soft stop");
    expw("R4 stays off", 0, 0);
    off_req = 0;
    soft_start("R4 restart");
    expw("R4 run high", T, 0);
    expw("R4 run low", 0, 0);
    // R8 overvoltage with stop mode
    ovp_prot = 1; ovp_cont = 0;
    soft_stop("R8 soft stop");
    expw("R8 held off", 0, 0);
    chk("R8 no flag", int'(ovp_flag), 0);
    ovp_prot = 0;
    soft_start("R8 restart");
    expw("R8 run high", T, 0);
    // R5 power-on reset
    idle(1);
    chk("R3 high held", int'(hdrive), 1);
    por = 1; #1;
    chk("R5 same-cycle cut", int'(hdrive), 0);
    idle(2); por = 0; idle(1);
    expw("R5 needs reload", 0, 0);
    regs_loaded = 0; idle(1); regs_loaded = 1; idle(1);
    expw("R5 needs calibration", 0, 0);
    cal_done = 0; idle(1); cal_done = 1; idle(2);
    soft_start("R5 restart");
    expw("R5 run high", T, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule